// File: doc/BRIEF.md
# Cache-Block Access Check Sequencer

This unit prepares the memory-permission verdict for a cache-block management operation (clean, flush or invalidate of one block). A start strobe delivers the address the instruction supplied. The unit clears the low bits of that address to get the address of the whole block. It asks an external translator for the physical address of the block. Then it asks an external permission checker two questions about the whole block: may it be read, and may it be written.

The operation is allowed when either question is answered yes. A fetch-only permission counts for nothing, because only read and write are ever asked. Every failure is reported as a store-class exception: a load-flavoured fault is promoted to its store counterpart. When both permission checks fail, the write check supplies the fault. The fault address is always the unaligned address the instruction gave.

A one-cycle done pulse carries the verdict. The pipeline stage that launched the operation uses it to retire the operation or to raise the exception. Translation, protection logic and the caches themselves live outside this unit.

Top module: `cbo_blk_check`

## Requirements
- R1: After reset the unit is idle: `done`, `xlat_req` and `perm_req` are all 0.
- R2: After a start, `xlat_req` rises carrying `xlat_vaddr` equal to the start address with its low `BLK_LOG2` bits cleared. Request and address hold until a cycle with `xlat_rsp_valid` high.
- R3: After a successful translation the unit makes exactly two permission queries on the translated address `xlat_paddr`: first a read (`perm_write`=0), then a write (`perm_write`=1). Each query is held until `perm_rsp_valid`, and the two are never asked together with a translation request.
- R4: If either query returns `perm_ok`=1, the result has `res_ok`=1, `res_cause`=0 and `res_ierr`=0.
- R5: If both queries fail, the reported cause is derived from the write query's cause, not the read query's.
- R6: Causes are mapped to the store class: 5 (load access) and 7 (store access) both become 7, and 13 (load page) and 15 (store page) both become 15. A failed translation reports its own cause mapped the same way, and no permission query is made for it.
- R7: At done, `fault_addr` equals the unaligned start address, for aligned and misaligned starts alike.
- R8: A cause that is none of 5, 7, 13 or 15 gives `res_ierr`=1 and `res_ok`=0, and the raw cause is passed through on `res_cause`.
- R9: `done` is high for exactly one cycle per operation. A start that arrives while an operation is in progress is ignored and does not alter that operation's addresses or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, taken only when idle |
| base_addr | input | ADDR_W | Address supplied by the operation |
| xlat_req | output | 1 | Translation request |
| xlat_vaddr | output | ADDR_W | Block-aligned virtual address to translate |
| xlat_rsp_valid | input | 1 | Translation answer present |
| xlat_ok | input | 1 | Translation succeeded |
| xlat_paddr | input | ADDR_W | Translated physical address |
| xlat_cause | input | 5 | Translation fault cause |
| perm_req | output | 1 | Permission query |
| perm_write | output | 1 | 0 asks about reading, 1 about writing |
| perm_paddr | output | ADDR_W | Physical block address under query |
| perm_rsp_valid | input | 1 | Permission answer present |
| perm_ok | input | 1 | Access permitted over the whole block |
| perm_cause | input | 5 | Permission fault cause |
| done | output | 1 | One-cycle completion pulse |
| res_ok | output | 1 | Operation allowed |
| res_cause | output | 5 | Exception cause when not allowed |
| res_ierr | output | 1 | Unexpected cause seen |
| fault_addr | output | ADDR_W | Address to report with the exception |

## Verification
Some properties are checked by the assertions on every cycle. These are the single-cycle done pulse, the mutual exclusion of translation and permission requests, and the alignment and stability of a pending translation request. They also check that a failed verdict carries only a store-class cause unless the internal-error flag is set, and that a stray start leaves the in-flight address alone. Other properties only the bench's scenarios can show, because they depend on what the stubbed translator and checker answered. These are the choice of the write fault when both checks fail, the exact mapping of each cause, the read-then-write order on the translated address, the absence of queries after a failed translation, and the reproduction of a misaligned start address.

// File: rtl/cbo_blk_check.sv
module cbo_blk_check #(
  parameter int ADDR_W   = 32,
  parameter int BLK_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              xlat_req,
  output logic [ADDR_W-1:0] xlat_vaddr,
  input  logic              xlat_rsp_valid,
  input  logic              xlat_ok,
  input  logic [ADDR_W-1:0] xlat_paddr,
  input  logic [4:0]        xlat_cause,
  output logic              perm_req,
  output logic              perm_write,
  output logic [ADDR_W-1:0] perm_paddr,
  input  logic              perm_rsp_valid,
  input  logic              perm_ok,
  input  logic [4:0]        perm_cause,
  output logic              done,
  output logic              res_ok,
  output logic [4:0]        res_cause,
  output logic              res_ierr,
  output logic [ADDR_W-1:0] fault_addr
);
  localparam logic [4:0] C_LD_ACC = 5'd5;
  localparam logic [4:0] C_ST_ACC = 5'd7;
  localparam logic [4:0] C_LD_PG  = 5'd13;
  localparam logic [4:0] C_ST_PG  = 5'd15;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << BLK_LOG2) - 64'd1);

  typedef enum logic [2:0] {S_IDLE, S_XLAT, S_RD, S_WR, S_DONE} state_t;
  state_t state;

  logic [ADDR_W-1:0] base_q, paddr_q, aligned, offset;
  logic              rd_ok_q, busy;

  function automatic logic [5:0] to_store(input logic [4:0] c);
    case (c)
      C_LD_ACC, C_ST_ACC: to_store = {1'b0, C_ST_ACC};
      C_LD_PG,  C_ST_PG:  to_store = {1'b0, C_ST_PG};
      default:            to_store = {1'b1, c};
    endcase
  endfunction

  assign aligned    = base_q & ~LOW_MASK;
  assign offset     = aligned - base_q;
  assign fault_addr = aligned - offset;
  assign busy       = (state != S_IDLE);

  assign xlat_req   = (state == S_XLAT);
  assign xlat_vaddr = aligned;
  assign perm_req   = (state == S_RD) || (state == S_WR);
  assign perm_write = (state == S_WR);
  assign perm_paddr = paddr_q;
  assign done       = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      base_q    <= '0;
      paddr_q   <= '0;
      rd_ok_q   <= 1'b0;
      res_ok    <= 1'b0;
      res_cause <= '0;
      res_ierr  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          base_q    <= base_addr;
          res_ok    <= 1'b0;
          res_cause <= '0;
          res_ierr  <= 1'b0;
          state     <= S_XLAT;
        end
        S_XLAT: if (xlat_rsp_valid) begin
          if (xlat_ok) begin
            paddr_q <= xlat_paddr;
            state   <= S_RD;
          end else begin
            {res_ierr, res_cause} <= to_store(xlat_cause);
            state <= S_DONE;
          end
        end
        S_RD: if (perm_rsp_valid) begin
          rd_ok_q <= perm_ok;
          state   <= S_WR;
        end
        S_WR: if (perm_rsp_valid) begin
          if (perm_ok || rd_ok_q) begin
            res_ok    <= 1'b1;
            res_cause <= '0;
            res_ierr  <= 1'b0;
          end else begin
            {res_ierr, res_cause} <= to_store(perm_cause);
          end
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(xlat_req && perm_req)); // R3
  AST_XLAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req |-> ((xlat_vaddr & LOW_MASK) == '0)); // R2
  AST_XLAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req && !xlat_rsp_valid) |=> (xlat_req && $stable(xlat_vaddr))); // R2
  AST_STORE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_ok && !res_ierr) |-> (res_cause == C_ST_ACC || res_cause == C_ST_PG)); // R6
  AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_ok) |-> (res_cause == '0 && !res_ierr)); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(fault_addr)); // R9
endmodule

// File: tb/test_cbo_blk_check.sv
module test_cbo_blk_check;
  localparam int AW = 32;
  localparam int BL = 6;
  localparam logic [AW-1:0] PXOR = 32'h4000_0000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic xlat_req, xlat_rsp_valid, xlat_ok, perm_req, perm_write, perm_rsp_valid, perm_ok;
  logic [AW-1:0] xlat_vaddr, xlat_paddr, perm_paddr, fault_addr;
  logic [4:0] xlat_cause, perm_cause, res_cause;
  logic done, res_ok, res_ierr;

  logic gate = 1'b1;
  logic c_xok = 1'b1, c_rok = 1'b1, c_wok = 1'b1;
  logic [4:0] c_xc = 5'd0, c_rc = 5'd0, c_wc = 5'd0;

  int n_tests = 0, n_fail = 0;
  int rd_seen = 0, wr_seen = 0, order_err = 0, addr_err = 0, xaddr_err = 0;
  logic [AW-1:0] exp_paddr;

  always #2 clk = ~clk;

  assign xlat_rsp_valid = xlat_req & gate;
  assign xlat_ok        = c_xok;
  assign xlat_cause     = c_xc;
  assign xlat_paddr     = xlat_vaddr ^ PXOR;
  assign perm_rsp_valid = perm_req & gate;
  assign perm_ok        = perm_write ? c_wok : c_rok;
  assign perm_cause     = perm_write ? c_wc : c_rc;

  cbo_blk_check #(.ADDR_W(AW), .BLK_LOG2(BL)) i_cbo_blk_check (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .xlat_req(xlat_req), .xlat_vaddr(xlat_vaddr), .xlat_rsp_valid(xlat_rsp_valid),
    .xlat_ok(xlat_ok), .xlat_paddr(xlat_paddr), .xlat_cause(xlat_cause),
    .perm_req(perm_req), .perm_write(perm_write), .perm_paddr(perm_paddr),
    .perm_rsp_valid(perm_rsp_valid), .perm_ok(perm_ok), .perm_cause(perm_cause),
    .done(done), .res_ok(res_ok), .res_cause(res_cause), .res_ierr(res_ierr),
    .fault_addr(fault_addr));

  always @(negedge clk) begin
    if (xlat_req && (xlat_vaddr != (exp_paddr ^ PXOR))) xaddr_err++;
    if (perm_req && perm_rsp_valid) begin
      if (perm_paddr != exp_paddr) addr_err++;
      if (!perm_write) begin
        if (rd_seen != 0 || wr_seen != 0) order_err++;
        rd_seen++;
      end else begin
        if (rd_seen != 1 || wr_seen != 0) order_err++;
        wr_seen++;
      end
    end
  end

  task automatic check(input bit cond, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_map(input logic [4:0] c);
    if (c == 5'd5 || c == 5'd7) return {1'b0, 5'd7};
    if (c == 5'd13 || c == 5'd15) return {1'b0, 5'd15};
    return {1'b1, c};
  endfunction

  function automatic logic [4:0] pick_cause();
    int r = $urandom_range(0, 9);
    if (r < 2) return 5'd5;
    if (r < 4) return 5'd7;
    if (r < 6) return 5'd13;
    if (r < 8) return 5'd15;
    return 5'($urandom_range(0, 31));
  endfunction

  task automatic run_op(input logic [AW-1:0] a, input bit stray);
    logic [5:0] em;
    bit eok;
    int queries, waited;
    exp_paddr = (a & ~32'h3F) ^ PXOR;
    rd_seen = 0; wr_seen = 0; order_err = 0; addr_err = 0; xaddr_err = 0;
    if (!c_xok) begin
      em = exp_map(c_xc); eok = 1'b0; queries = 0;
    end else begin
      queries = 2;
      eok = c_rok | c_wok;
      em = eok ? 6'd0 : exp_map(c_wc);
    end
    @(negedge clk); start = 1'b1; base_addr = a;
    @(negedge clk); start = stray; base_addr = ~a;
    @(negedge clk); start = 1'b0;
    waited = 0;
    while (!done && waited < 200) begin
      gate = ($urandom_range(0, 9) < 7);
      @(negedge clk); waited++;
    end
    gate = 1'b1;
    check(done, "R9", "done seen", AW'(done), 1);
    check(res_ok == eok, "R4", "res_ok", AW'(res_ok), AW'(eok));
    check(res_cause == em[4:0], c_xok ? "R5" : "R6", "res_cause", AW'(res_cause), AW'(em[4:0]));
    check(res_ierr == em[5], "R8", "res_ierr", AW'(res_ierr), AW'(em[5]));
    check(fault_addr == a, "R7", "fault_addr", fault_addr, a);
    check(rd_seen + wr_seen == queries && order_err == 0, "R3", "queries",
          AW'(rd_seen + wr_seen), AW'(queries));
    check(addr_err == 0, "R3", "perm address errors", AW'(addr_err), 0);
    check(xaddr_err == 0, "R2", "aligned translate address errors", AW'(xaddr_err), 0);
    @(negedge clk);
    check(!done, "R9", "done after pulse", AW'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!done && !xlat_req && !perm_req, "R1", "idle in reset",
          AW'({done, xlat_req, perm_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !xlat_req && !perm_req, "R1", "idle after reset",
          AW'({done, xlat_req, perm_req}), 0);

    c_xok = 1; c_rok = 1; c_wok = 1;
    run_op(32'h0000_1000, 0);                                   // R4 aligned
    c_rok = 0; c_rc = 5'd5; c_wok = 1;
    run_op(32'h0000_1037, 0);                                   // R4 write only, misaligned R7
    c_rok = 1; c_wok = 0; c_wc = 5'd7;
    run_op(32'h1234_567F, 1);                                   // R4 read only, stray start R9
    c_rok = 0; c_rc = 5'd13; c_wok = 0; c_wc = 5'd5;
    run_op(32'h0000_2001, 0);                                   // R5 write cause wins
    c_rc = 5'd5; c_wc = 5'd13;
    run_op(32'h0000_2040, 1);                                   // R5/R6 page
    c_wc = 5'd15;
    run_op(32'hFFFF_FFFF, 0);                                   // R6 store page unchanged
    c_xok = 0; c_xc = 5'd13;
    run_op(32'h8000_0003, 0);                                   // R6 translation page
    c_xc = 5'd5;
    run_op(32'h8000_0040, 0);                                   // R6 translation access
    c_xc = 5'd2;
    run_op(32'h0000_0010, 0);                                   // R8 unknown translate cause
    c_xok = 1; c_rok = 0; c_wok = 0; c_wc = 5'd12;
    run_op(32'h0000_0020, 0);                                   // R8 unknown permission cause

    for (int i = 0; i < 300; i++) begin
      c_xok = ($urandom_range(0, 3) != 0);
      c_xc = pick_cause();
      c_rok = $urandom_range(0, 1);
      c_wok = $urandom_range(0, 1);
      c_rc = pick_cause();
      c_wc = pick_cause();
      run_op($urandom(), $urandom_range(0, 1));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule